// File: doc/BRIEF.md
# Two-Way Data Cache with Run-Time Write Policy

This block is a small two-way set-associative data cache that sits between a CPU word port and a word-wide main-memory port. The CPU presents a request with an address, a direction and write data, and holds it until the cache raises `cpu_ready`. A read that hits completes in the cycle it is presented. A read that misses stalls the CPU while the cache fetches the whole 64-byte line (sixteen 32-bit words), one word per memory handshake. If the line it replaces is dirty, that line is first copied back to memory. The cache then serves the request from the newly installed line.

Each line holds a tag, sixteen data words, a valid bit and a dirty bit. Each set keeps one LRU bit that names the way to replace next. The `wb_mode` input selects the write policy at run time and is sampled on every write hit. In write-through mode, a write hit updates both the line and memory. In write-back mode, a write hit updates only the line and marks it dirty. A write miss always goes to memory and leaves the cache unchanged.

Writes to memory are posted through a single-entry store buffer. Read hits keep being served while that store drains. A new write, or any miss, waits until the buffered store has completed.

Top module: `wp_dcache`

## Requirements
- R1: After reset no line is valid or dirty and every set's LRU bit selects way 0. The memory port is idle, and the first access to any address misses.
- R2: A read miss fetches the full 16-word line from memory with reads (`mem_we`=0). The beats run in ascending word order from the 64-byte-aligned line base, one word per beat. After the fill, the requested word is returned.
- R3: A read hit returns the stored word with `cpu_ready` high in the same cycle as the request and starts no memory transfer.
- R4: A write miss produces exactly one memory write of the CPU word at its address. It allocates no line, so a later read of that line still misses.
- R5: With `wb_mode`=0, a write hit updates the cached word and also writes that word to memory.
- R6: With `wb_mode`=1, a write hit updates only the cached word and marks the line dirty. Memory is not written.
- R7: When a dirty line is replaced, its 16 words are written back to their old addresses, and all of these writes complete before the first fill read. A clean victim causes no memory write.
- R8: The victim on a miss is the least-recently-used way of the set. Read hits, write hits and line fills each make the touched way the most recently used.
- R9: While a posted store is waiting on the memory port, read hits are still answered in the cycle they are presented.
- R10: While a posted store is pending, a new write or a read miss is held with `cpu_ready` low until that store's handshake completes.
- R11: A memory beat transfers when `mem_valid` and `mem_ready` are both high. Until then, `mem_valid`, `mem_addr` and `mem_we` stay unchanged.
- R12: The write policy can change between any two requests. Reads always return the most recently written value for an address, under any mix of the two policies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | Write policy: 1 write-back, 0 write-through |
| cpu_req | input | 1 | CPU request, held until accepted |
| cpu_we | input | 1 | CPU request is a write |
| cpu_addr | input | 32 | CPU byte address (word aligned) |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, valid with `cpu_ready` on a read |
| cpu_ready | output | 1 | Request accepted this cycle |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 32 | Memory word address (byte units) |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | 32 | Memory read data for a read beat |

## Verification
Directed sequences build each set's state step by step. Two tags filling one set, followed by a third tag, show whether the replacement picks the least-recently-used way rather than a fixed or the most recent one. Repeating the same sequence with a dirty line shows whether the copy-back comes before the fill, and whether a clean victim causes no write at all. Holding memory ready low while a store is posted separates three cases: read hits that pass the store, writes that must wait, and misses that must wait. A random mix of reads and writes over a few conflicting tags, with the policy toggled every few dozen requests, is checked against a flat reference memory. This catches stale data left behind by any combination of dirty lines, bypassed write misses and posted stores.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    ST_LOOKUP   = 2'd0,
    ST_COPYBACK = 2'd1,
    ST_REFILL   = 2'd2
  } wpc_state_e;
endpackage

// File: rtl/wpc_tags.sv
module wpc_tags #(
  parameter int NUM_SETS = 8,
  parameter int TAG_W    = 23,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [1:0]       hit_vec,
  output logic             vic_way,
  output logic             vic_valid,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic             touch_way,
  input  logic             dirty_en,
  input  logic [SET_W-1:0] dirty_set,
  input  logic             dirty_way,
  input  logic             inst_en,
  input  logic [SET_W-1:0] inst_set,
  input  logic             inst_way,
  input  logic [TAG_W-1:0] inst_tag
);
  logic [1:0]       vld_w;
  logic [1:0]       drt_w;
  logic [TAG_W-1:0] tag_w [2];
  logic [NUM_SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [NUM_SETS-1:0] v_q;
    logic [NUM_SETS-1:0] d_q;
    logic [TAG_W-1:0]    t_q [NUM_SETS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= '0;
        d_q <= '0;
      end else if (inst_en && inst_way == 1'(w)) begin
        v_q[inst_set] <= 1'b1;
        d_q[inst_set] <= 1'b0;
      end else if (dirty_en && dirty_way == 1'(w)) begin
        d_q[dirty_set] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (inst_en && inst_way == 1'(w)) t_q[inst_set] <= inst_tag;
    end

    assign hit_vec[w] = v_q[lk_set] && (t_q[lk_set] == lk_tag);
    assign vld_w[w]   = v_q[lk_set];
    assign drt_w[w]   = d_q[lk_set];
    assign tag_w[w]   = t_q[lk_set];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        lru_q <= '0;
    else if (touch_en) lru_q[touch_set] <= ~touch_way;
  end

  assign vic_way   = lru_q[lk_set];
  assign vic_valid = vld_w[vic_way];
  assign vic_dirty = drt_w[vic_way];
  assign vic_tag   = tag_w[vic_way];

  // R8: a set never holds the same tag in both ways
  p_single_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R1: a dirty line is always a valid one
  p_dirty_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vic_dirty |-> vic_valid);
endmodule

// File: rtl/wpc_data.sv
module wpc_data #(
  parameter int NUM_SETS   = 8,
  parameter int LINE_WORDS = 16,
  parameter int DATA_W     = 32,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int WORD_W    = $clog2(LINE_WORDS),
  localparam int IDX_W     = 1 + SET_W + WORD_W,
  localparam int DEPTH     = 2 * NUM_SETS * LINE_WORDS
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_way,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);
  function automatic logic [IDX_W-1:0] f_idx(input logic w,
                                             input logic [SET_W-1:0] s,
                                             input logic [WORD_W-1:0] d);
    return {w, s, d};
  endfunction

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[f_idx(wr_way, wr_set, wr_word)] <= wr_data;
  end

  assign rd_data = store_q[f_idx(rd_way, rd_set, rd_word)];
endmodule

// File: rtl/wp_dcache.sv
module wp_dcache
  import wpc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 16,
  parameter int NUM_SETS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int TAG_W  = ADDR_W - BYTE_W - WORD_W - SET_W;

  function automatic logic [WORD_W-1:0] f_word(input logic [ADDR_W-1:0] a);
    return a[BYTE_W +: WORD_W];
  endfunction
  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[BYTE_W + WORD_W +: SET_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_join(input logic [TAG_W-1:0] t,
                                               input logic [SET_W-1:0] s,
                                               input logic [WORD_W-1:0] w);
    return {t, s, w, {BYTE_W{1'b0}}};
  endfunction

  wpc_state_e        state_q;
  logic [WORD_W-1:0] beat_q;
  logic              way_q;
  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;
  logic [TAG_W-1:0]  vtag_q;
  logic              wbuf_v_q;
  logic [ADDR_W-1:0] wbuf_a_q;
  logic [DATA_W-1:0] wbuf_d_q;

  logic [SET_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic [1:0]        hit_vec;
  logic              vic_way, vic_valid, vic_dirty;
  logic [TAG_W-1:0]  vic_tag;
  logic [DATA_W-1:0] rd_data;

  // named internal events
  logic in_lookup, any_hit, hit_way;
  logic ev_rd_hit, ev_rd_miss, wr_go;
  logic ev_wr_hit_wt, ev_wr_hit_wb, ev_wr_miss;
  logic ev_beat, beat_last, ev_fill_done;

  logic unused_addr_bits;
  assign unused_addr_bits = ^cpu_addr[BYTE_W-1:0];

  assign lk_set       = f_set(cpu_addr);
  assign lk_tag       = f_tag(cpu_addr);
  assign in_lookup    = (state_q == ST_LOOKUP);
  assign any_hit      = |hit_vec;
  assign hit_way      = hit_vec[1];
  assign ev_rd_hit    = in_lookup && cpu_req && !cpu_we && any_hit;
  assign ev_rd_miss   = in_lookup && cpu_req && !cpu_we && !any_hit && !wbuf_v_q;
  assign wr_go        = in_lookup && cpu_req && cpu_we && !wbuf_v_q;
  assign ev_wr_hit_wb = wr_go && any_hit && wb_mode;
  assign ev_wr_hit_wt = wr_go && any_hit && !wb_mode;
  assign ev_wr_miss   = wr_go && !any_hit;
  assign ev_beat      = mem_valid && mem_ready;
  assign beat_last    = (beat_q == WORD_W'(LINE_WORDS - 1));
  assign ev_fill_done = (state_q == ST_REFILL) && ev_beat && beat_last;

  assign cpu_ready = ev_rd_hit || wr_go;
  assign cpu_rdata = rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_LOOKUP;
      beat_q  <= '0;
      way_q   <= 1'b0;
      set_q   <= '0;
      tag_q   <= '0;
      vtag_q  <= '0;
    end else begin
      case (state_q)
        ST_LOOKUP: if (ev_rd_miss) begin
          way_q   <= vic_way;
          set_q   <= lk_set;
          tag_q   <= lk_tag;
          vtag_q  <= vic_tag;
          beat_q  <= '0;
          state_q <= (vic_valid && vic_dirty) ? ST_COPYBACK : ST_REFILL;
        end
        ST_COPYBACK: if (ev_beat) begin
          beat_q <= beat_q + 1'b1;
          if (beat_last) state_q <= ST_REFILL;
        end
        ST_REFILL: if (ev_beat) begin
          beat_q <= beat_q + 1'b1;
          if (beat_last) state_q <= ST_LOOKUP;
        end
        default: state_q <= ST_LOOKUP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbuf_v_q <= 1'b0;
      wbuf_a_q <= '0;
      wbuf_d_q <= '0;
    end else if (ev_wr_hit_wt || ev_wr_miss) begin
      wbuf_v_q <= 1'b1;
      wbuf_a_q <= cpu_addr;
      wbuf_d_q <= cpu_wdata;
    end else if (in_lookup && ev_beat) begin
      wbuf_v_q <= 1'b0;
    end
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b1;
    mem_addr  = wbuf_a_q;
    mem_wdata = wbuf_d_q;
    case (state_q)
      ST_LOOKUP: mem_valid = wbuf_v_q;
      ST_COPYBACK: begin
        mem_valid = 1'b1;
        mem_addr  = f_join(vtag_q, set_q, beat_q);
        mem_wdata = rd_data;
      end
      ST_REFILL: begin
        mem_valid = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = f_join(tag_q, set_q, beat_q);
        mem_wdata = '0;
      end
      default: mem_valid = 1'b0;
    endcase
  end

  logic              refill_beat;
  logic              dw_en, dw_way, dr_way;
  logic [SET_W-1:0]  dw_set, dr_set;
  logic [WORD_W-1:0] dw_word, dr_word;
  logic [DATA_W-1:0] dw_data;

  assign refill_beat = (state_q == ST_REFILL) && ev_beat;
  assign dw_en   = ev_wr_hit_wt || ev_wr_hit_wb || refill_beat;
  assign dw_way  = (state_q == ST_REFILL) ? way_q  : hit_way;
  assign dw_set  = (state_q == ST_REFILL) ? set_q  : lk_set;
  assign dw_word = (state_q == ST_REFILL) ? beat_q : f_word(cpu_addr);
  assign dw_data = (state_q == ST_REFILL) ? mem_rdata : cpu_wdata;
  assign dr_way  = (state_q == ST_COPYBACK) ? way_q  : hit_way;
  assign dr_set  = (state_q == ST_COPYBACK) ? set_q  : lk_set;
  assign dr_word = (state_q == ST_COPYBACK) ? beat_q : f_word(cpu_addr);

  wpc_data #(.NUM_SETS(NUM_SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .wr_en(dw_en), .wr_way(dw_way), .wr_set(dw_set),
    .wr_word(dw_word), .wr_data(dw_data), .rd_way(dr_way), .rd_set(dr_set),
    .rd_word(dr_word), .rd_data(rd_data)
  );

  wpc_tags #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_set(lk_set), .lk_tag(lk_tag),
    .hit_vec(hit_vec), .vic_way(vic_way), .vic_valid(vic_valid),
    .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .touch_en(ev_rd_hit || ev_wr_hit_wt || ev_wr_hit_wb || ev_fill_done),
    .touch_set(ev_fill_done ? set_q : lk_set),
    .touch_way(ev_fill_done ? way_q : hit_way),
    .dirty_en(ev_wr_hit_wb), .dirty_set(lk_set), .dirty_way(hit_way),
    .inst_en(ev_fill_done), .inst_set(set_q), .inst_way(way_q), .inst_tag(tag_q)
  );

  p_fill_is_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REFILL) && mem_valid |-> !mem_we);

  p_hit_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_hit |=> state_q == ST_LOOKUP);

  p_wmiss_no_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_miss |=> (state_q == ST_LOOKUP) && wbuf_v_q);

  p_wb_hit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_hit_wb |=> !wbuf_v_q);

  p_copyback_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COPYBACK) && ev_beat && beat_last |=> state_q == ST_REFILL);

  p_stall_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_lookup && cpu_req && wbuf_v_q && (cpu_we || !any_hit) |-> !cpu_ready);

  p_hold_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));
endmodule

// File: tb/sim_wp_dcache.sv
module sim_wp_dcache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_mode = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b0;

  always #2 clk = ~clk;

  wp_dcache u0 (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .cpu_req(cpu_req),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_valid(mem_valid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem_model [1024];
  logic [31:0] arch [1024];
  int rd_beats = 0, wr_beats = 0, seq_bad = 0, hs_bad = 0, wr_after_rd = 0;
  bit seen_rd = 0, hold_mem = 0, prev_pend = 0;
  logic [31:0] fill_base = '0, prev_addr = '0;

  function automatic logic [31:0] seed_word(input int i);
    return (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [31:0] line_addr(input int tag, input int set);
    return 32'((tag << 9) | (set << 6));
  endfunction

  assign mem_rdata = mem_model[mem_addr[11:2]];

  always @(negedge clk) mem_ready = hold_mem ? 1'b0 : (($urandom % 4) != 0);

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_pend && (!mem_valid || mem_addr != prev_addr)) hs_bad++;
      prev_pend = mem_valid && !mem_ready;
      prev_addr = mem_addr;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mem_model[mem_addr[11:2]] <= mem_wdata;
          wr_beats++;
          if (seen_rd) wr_after_rd++;
        end else begin
          if (rd_beats % 16 == 0) begin
            fill_base = mem_addr;
            if (mem_addr[5:0] != 6'd0) seq_bad++;
          end else if (mem_addr != fill_base + 32'(4 * (rd_beats % 16))) seq_bad++;
          rd_beats++;
          seen_rd = 1;
        end
      end
    end
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; waits = 0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; waits++; end
    rd = cpu_rdata;
    if (we) arch[a[11:2]] = d;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk); #1;
    while (mem_valid) begin @(negedge clk); #1; end
  endtask

  initial begin
    logic [31:0] rd, a_addr, b_addr, c_addr, d_addr, e_addr;
    int w, w2, r0, wr0;
    void'($urandom(32'd2718));
    for (int i = 0; i < 1024; i++) begin
      mem_model[i] = seed_word(i);
      arch[i] = seed_word(i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(mem_valid == 1'b0, "R1 mem idle", 32'(mem_valid), 0);
    check(cpu_ready == 1'b0, "R1 no ready", 32'(cpu_ready), 0);

    // R1/R2: first read misses and fills a full line in order
    a_addr = line_addr(0, 1) + 20;
    r0 = rd_beats;
    cpu_op(0, a_addr, 0, rd, w);
    check(rd_beats - r0 == 16, "R1 R2 fill beats", 32'(rd_beats - r0), 16);
    check(rd == arch[a_addr[11:2]], "R2 fill data", rd, arch[a_addr[11:2]]);
    check(seq_bad == 0, "R2 beat order", 32'(seq_bad), 0);

    // R3: read hit same line
    r0 = rd_beats;
    cpu_op(0, a_addr + 8, 0, rd, w);
    check(rd_beats == r0 && w == 0, "R3 hit no fetch", 32'(rd_beats - r0), 0);
    check(rd == arch[(a_addr + 8) >> 2], "R3 hit data", rd, arch[(a_addr + 8) >> 2]);

    // R4: write miss bypasses, even in write-back mode
    wb_mode = 1'b1;
    b_addr = line_addr(3, 2);
    wr0 = wr_beats;
    cpu_op(1, b_addr, 32'hCAFE_0004, rd, w);
    drain();
    check(wr_beats - wr0 == 1, "R4 one write", 32'(wr_beats - wr0), 1);
    check(mem_model[b_addr[11:2]] == 32'hCAFE_0004, "R4 mem data", mem_model[b_addr[11:2]], 32'hCAFE_0004);
    r0 = rd_beats;
    cpu_op(0, b_addr, 0, rd, w);
    check(rd_beats - r0 == 16, "R4 no allocate", 32'(rd_beats - r0), 16);
    check(rd == 32'hCAFE_0004, "R4 read back", rd, 32'hCAFE_0004);

    // R5: write-through hit
    wb_mode = 1'b0;
    cpu_op(1, a_addr, 32'hBEEF_0005, rd, w);
    drain();
    check(mem_model[a_addr[11:2]] == 32'hBEEF_0005, "R5 mem updated", mem_model[a_addr[11:2]], 32'hBEEF_0005);
    r0 = rd_beats;
    cpu_op(0, a_addr, 0, rd, w);
    check(rd == 32'hBEEF_0005 && rd_beats == r0, "R5 cache updated", rd, 32'hBEEF_0005);

    // R6: write-back hit
    wb_mode = 1'b1;
    wr0 = wr_beats;
    cpu_op(1, line_addr(0, 1) + 32, 32'hD00D_0006, rd, w);
    repeat (6) @(negedge clk);
    check(wr_beats == wr0 && w == 0, "R6 no mem write", 32'(wr_beats - wr0), 0);
    check(mem_model[(line_addr(0, 1) + 32) >> 2] == seed_word(int'((line_addr(0, 1) + 32) >> 2)),
          "R6 mem unchanged", mem_model[(line_addr(0, 1) + 32) >> 2], seed_word(int'((line_addr(0, 1) + 32) >> 2)));
    cpu_op(0, line_addr(0, 1) + 32, 0, rd, w);
    check(rd == 32'hD00D_0006, "R6 cache data", rd, 32'hD00D_0006);

    // R8/R7: LRU replacement and copy-back order in set 1
    c_addr = line_addr(1, 1);
    wr0 = wr_beats;
    cpu_op(0, c_addr, 0, rd, w);                 // fills way1, clean victim
    check(wr_beats == wr0, "R7 clean victim", 32'(wr_beats - wr0), 0);
    cpu_op(0, a_addr, 0, rd, w);                 // touch A
    d_addr = line_addr(2, 1);
    wr0 = wr_beats;
    cpu_op(0, d_addr, 0, rd, w);                 // evicts C
    check(wr_beats == wr0, "R8 clean LRU victim", 32'(wr_beats - wr0), 0);
    r0 = rd_beats;
    cpu_op(0, a_addr, 0, rd, w);
    check(rd_beats == r0 && rd == 32'hBEEF_0005, "R8 recent kept", 32'(rd_beats - r0), 0);
    r0 = rd_beats;
    cpu_op(0, c_addr, 0, rd, w);                 // refetch C into way1
    check(rd_beats - r0 == 16, "R8 LRU evicted", 32'(rd_beats - r0), 16);
    wr0 = wr_beats; r0 = rd_beats; wr_after_rd = 0; seen_rd = 0;
    cpu_op(0, line_addr(4, 1), 0, rd, w);        // evicts dirty A
    check(wr_beats - wr0 == 16, "R7 copyback beats", 32'(wr_beats - wr0), 16);
    check(rd_beats - r0 == 16, "R7 fill beats", 32'(rd_beats - r0), 16);
    check(wr_after_rd == 0, "R7 copyback first", 32'(wr_after_rd), 0);
    check(mem_model[(line_addr(0, 1) + 32) >> 2] == 32'hD00D_0006, "R7 dirty data home",
          mem_model[(line_addr(0, 1) + 32) >> 2], 32'hD00D_0006);

    // R9/R10: posted store pending
    wb_mode = 1'b0;
    e_addr = line_addr(0, 3);
    cpu_op(0, e_addr, 0, rd, w);
    hold_mem = 1; repeat (2) @(negedge clk);
    wr0 = wr_beats;
    cpu_op(1, e_addr, 32'h0909_0009, rd, w);
    cpu_op(0, e_addr + 4, 0, rd, w);
    check(w == 0 && wr_beats == wr0, "R9 hit during store", 32'(w), 0);
    check(rd == arch[(e_addr + 4) >> 2], "R9 hit data", rd, arch[(e_addr + 4) >> 2]);
    fork
      cpu_op(1, e_addr + 8, 32'h1010_0010, rd, w2);
      begin repeat (8) @(negedge clk); hold_mem = 0; end
    join
    check(w2 >= 6, "R10 write stalls", 32'(w2), 6);
    drain();
    hold_mem = 1; repeat (2) @(negedge clk);
    cpu_op(1, line_addr(6, 5), 32'h1111_0011, rd, w);
    fork
      cpu_op(0, line_addr(5, 3), 0, rd, w2);
      begin repeat (8) @(negedge clk); hold_mem = 0; end
    join
    check(w2 >= 6, "R10 miss stalls", 32'(w2), 6);
    check(rd == arch[line_addr(5, 3) >> 2], "R10 miss data", rd, arch[line_addr(5, 3) >> 2]);

    // R12: random mix of policies
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra;
      bit rw;
      if (k % 40 == 0) begin drain(); wb_mode = ~wb_mode; end
      ra = line_addr(int'($urandom % 6), int'($urandom % 2)) + 32'(4 * ($urandom % 16));
      rw = ($urandom % 3) == 0;
      cpu_op(rw, ra, $urandom, rd, w);
      if (!rw) check(rd == arch[ra[11:2]], "R12 random read", rd, arch[ra[11:2]]);
    end
    drain();
    check(hs_bad == 0, "R11 handshake hold", 32'(hs_bad), 0);
    check(seq_bad == 0, "R2 all fills ordered", 32'(seq_bad), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule